// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that sits in front of a byte-wide storage array modelled as registers. It oversamples SCL and SDA with the system clock and recognises START and STOP. It answers the control byte that carries its device type and three strap bits. It then accepts one word-address byte and either collects data bytes for a write or returns bytes for a read.

Write data is staged in a 16-byte page buffer and goes into the array only when a STOP closes the write. A write-protect input blocks that commit. After a commit, a self-timed programming window of a parameterised number of clocks begins. During that window the target leaves SDA released and does not acknowledge its own address. Reads start at the current address and advance through the whole array. A random read is done by sending a write with only the word address, then a repeated START with the read bit set.

The SDA pin is open-drain: `sda_oe_o` high pulls the line low. There is no streaming interface. The bus is paced only by SCL, and all other pins are plain levels.

Top module: `i2c_eeprom_target`

## Requirements
- R1: SDA falling while SCL is high is a START and starts reception of a control byte, even in the middle of a transfer. SDA rising while SCL is high is a STOP and returns the target to idle.
- R2: The control byte is sent MSB first as 1010, then the strap bits A2 A1 A0, then the R/W bit (0 = write, 1 = read). On a match, the target pulls SDA low for the ninth SCL clock. On a mismatch it leaves SDA released and ignores the bus until the next START.
- R3: In a write, the byte after the control byte is the word address, kept modulo WORDS. Each following data byte is acknowledged and staged. The staged bytes reach the array only at a STOP; a repeated START discards them.
- R4: During a write, only the low four address bits advance after each data byte, wrapping from 0xF to 0x0. The upper bits keep the page.
- R5: A commit starts a programming window of PROG_CYCLES clocks. During the window the target never drives SDA and does not acknowledge any control byte. After the window it acknowledges again.
- R6: When wp_i is high at the STOP, data bytes are still acknowledged, but nothing is stored and no programming window starts.
- R7: A read returns the byte at the current address, MSB first. The target changes each bit while SCL is low. A write carrying only a word address, followed by a repeated START with R/W = 1, reads from that address.
- R8: After each read byte the address goes up by one over the whole array, wrapping from WORDS-1 to 0. A master ACK (SDA low on the ninth clock) brings the next byte. A master NACK leaves SDA released until the next START.
- R9: After reset, SDA is released and every array byte reads 0xFF.
- R10: The target never changes its SDA drive while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| dev_pins_i | input | 3 | Strap bits A2 A1 A0 compared with the control byte |
| wp_i | input | 1 | Write protect; high blocks every commit |

## Verification
The bench builds the block with WORDS = 128 and PROG_CYCLES = 400. The small array lets a sequential read from the last address wrap to address 0 within a few bytes. The short programming window lets one test probe the target both inside the window and after it. With a 6-clock quarter period on SCL, a control byte fits well inside the window. Page wrap, write protect and strap mismatch are each run as directed transactions.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_NEXT} ee_state_e;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} rx_kind_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_ee_sampler.sv
module i2c_ee_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, sda_m, scl_s, sda_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_s <= 1'b1; sda_s <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; sda_m <= sda_i;
      scl_s <= scl_m; sda_s <= sda_m;
      scl_p <= scl_s; sda_p <= sda_s;
    end

  assign scl_o      = scl_s;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ee_prog_timer.sv
module i2c_ee_prog_timer #(
  parameter int PROG_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt <= '0;
    else if (start_i)       cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;

  assign busy_o = (cnt != '0);

  // R5: no commit may arrive while a programming window is running
  assert_no_commit_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
  parameter int WORDS = 256,
  parameter int PAGE  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(WORDS)-1:0]      rd_addr_i,
  output logic [7:0]                    rd_data_o,
  input  logic                          wr_en_i,
  input  logic [$clog2(WORDS)-$clog2(PAGE)-1:0] wr_page_i,
  input  logic [PAGE*8-1:0]             wr_data_i,
  input  logic [PAGE-1:0]               wr_mask_i
);
  localparam int AW = $clog2(WORDS);
  localparam int PW = $clog2(PAGE);

  logic [7:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= 8'hFF;
    end else if (wr_en_i) begin
      for (int i = 0; i < PAGE; i++)
        if (wr_mask_i[i]) mem[{wr_page_i, PW'(i)}] <= wr_data_i[i*8 +: 8];
    end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int WORDS       = 256,
  parameter int PROG_CYCLES = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] dev_pins_i,
  input  logic       wp_i
);
  import i2c_ee_pkg::*;

  localparam int PAGE = 16;
  localparam int AW   = $clog2(WORDS);
  localparam int PW   = $clog2(PAGE);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, commit;
  logic [7:0] rd_data;

  ee_state_e       st;
  rx_kind_e        kind;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic            rw;
  logic [AW-1:0]   addr_q;
  logic            sda_oe;
  logic [PAGE*8-1:0] pg_data;
  logic [PAGE-1:0] pg_mask;
  logic            pend;
  logic [PW-1:0]   idx;

  i2c_ee_sampler u_smp (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_ee_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk, .rst_n, .start_i(commit), .busy_o(busy)
  );

  i2c_ee_array #(.WORDS(WORDS), .PAGE(PAGE)) u_arr (
    .clk, .rst_n, .rd_addr_i(addr_q), .rd_data_o(rd_data),
    .wr_en_i(commit), .wr_page_i(addr_q[AW-1:PW]),
    .wr_data_i(pg_data), .wr_mask_i(pg_mask)
  );

  assign idx    = addr_q[PW-1:0];
  assign commit = stop_ev & pend & ~wp_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_CTRL; bitcnt <= '0; shreg <= '0; rw <= 1'b0;
      addr_q <= '0; sda_oe <= 1'b0; pg_data <= '0; pg_mask <= '0; pend <= 1'b0;
    end else if (start_ev) begin
      st <= ST_RX; kind <= K_CTRL; bitcnt <= '0; sda_oe <= 1'b0; pend <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; sda_oe <= 1'b0; pend <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            unique case (kind)
              K_CTRL:
                if (shreg[7:1] == {DEV_TYPE, dev_pins_i} && !busy) begin
                  rw <= shreg[0]; sda_oe <= 1'b1; st <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              K_ADDR: begin
                addr_q <= AW'(shreg); pg_mask <= '0; sda_oe <= 1'b1; st <= ST_ACK;
              end
              default: begin
                pg_data[idx*8 +: 8] <= shreg;
                pg_mask[idx]        <= 1'b1;
                addr_q[PW-1:0]      <= idx + PW'(1);
                pend   <= 1'b1;
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (kind == K_CTRL && rw) begin
            shreg <= rd_data; sda_oe <= ~rd_data[7]; bitcnt <= 4'd1; st <= ST_TX;
          end else begin
            sda_oe <= 1'b0; bitcnt <= '0; st <= ST_RX;
            kind   <= (kind == K_CTRL) ? K_ADDR : K_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0; addr_q <= addr_q + 1'b1; st <= ST_MACK;
          end else begin
            sda_oe <= ~shreg[6]; shreg <= {shreg[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_MACK: if (scl_rise) st <= sda_s ? ST_IDLE : ST_NEXT;
        ST_NEXT: if (scl_fall) begin
          shreg <= rd_data; sda_oe <= ~rd_data[7]; bitcnt <= 4'd1; st <= ST_TX;
        end
        default: ;
      endcase
    end

  assign sda_oe_o = sda_oe;

  // R10: SDA drive only moves while SCL is low
  assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R5: programming window keeps SDA released
  assert_busy_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R6: a protected STOP never opens a programming window
  assert_wp_no_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp_i) |-> !$rose(busy));

  // R8: the master owns SDA on its acknowledge clock
  assert_mack_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !sda_oe);

  // R4: a staged data byte never moves the page
  assert_page_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && kind == K_DATA && scl_fall && bitcnt == 4'd8 && !start_ev && !stop_ev)
      |=> $stable(addr_q[AW-1:PW]));
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int WORDS = 128;
  localparam int PROG  = 400;
  localparam int Q     = 6;
  typedef logic [7:0] bytes_t [16];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_oe;
  logic sda;
  int checks = 0, fails = 0, hi_moves = 0;
  bit done = 1'b0;
  logic scl_d = 1'b1, oe_d = 1'b0;

  always #2 clk = ~clk;
  assign sda = !(sda_oe || m_low);

  i2c_eeprom_target #(.WORDS(WORDS), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .dev_pins_i(pins), .wp_i(wp)
  );

  always @(negedge clk) begin
    if (rst_n && scl && scl_d && sda_oe != oe_d) hi_moves++;
    scl_d <= scl; oe_d <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
    end
    m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      qw(2); scl = 1'b1; qw(); b = {b[6:0], sda}; qw(); scl = 1'b0;
    end
    qw(); m_low = ~nack; qw(); scl = 1'b1; qw(2); scl = 1'b0; m_low = 1'b0; qw();
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] p, input bit r);
    return {4'b1010, p, r};
  endfunction

  task automatic write_seq(input logic [7:0] a, input bytes_t d, input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(ctl(pins, 1'b0), ack); chk(ack, "R2 control ack", ack, 1);
    send_byte(a, ack);               chk(ack, "R3 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); chk(ack, req, ack, 1);
    end
    i2c_stop();
  endtask

  task automatic read_seq(input logic [7:0] a, input int n, output bytes_t r);
    bit ack;
    i2c_start();
    send_byte(ctl(pins, 1'b0), ack); chk(ack, "R7 dummy write ack", ack, 1);
    send_byte(a, ack);
    i2c_start();
    send_byte(ctl(pins, 1'b1), ack); chk(ack, "R7 read control ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, r[i]);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic wait_prog();
    repeat (PROG + 100) @(negedge clk);
  endtask

  task automatic t_reset_erased();
    bytes_t r;
    chk(sda_oe == 1'b0, "R9 SDA released after reset", sda_oe, 0);
    read_seq(8'h40, 1, r);
    chk(r[0] == 8'hFF, "R9 erased byte", r[0], 8'hFF);
  endtask

  task automatic t_byte_write();
    bytes_t d, r;
    d[0] = 8'h5A;
    write_seq(8'h10, d, 1, "R1 R3 data ack");
    wait_prog();
    read_seq(8'h10, 1, r);
    chk(r[0] == 8'h5A, "R3 R7 byte written", r[0], 8'h5A);
  endtask

  task automatic t_busy();
    bytes_t d, r;
    bit ack;
    d[0] = 8'hC3;
    write_seq(8'h11, d, 1, "R3 data ack");
    i2c_start(); send_byte(ctl(pins, 1'b0), ack);
    chk(!ack, "R5 no ack in window", ack, 0);
    i2c_stop();
    wait_prog();
    i2c_start(); send_byte(ctl(pins, 1'b0), ack);
    chk(ack, "R5 ack after window", ack, 1);
    i2c_stop();
    read_seq(8'h11, 1, r);
    chk(r[0] == 8'hC3, "R5 committed value", r[0], 8'hC3);
  endtask

  task automatic t_page_wrap();
    bytes_t d, r;
    d[0] = 8'hA1; d[1] = 8'hA2; d[2] = 8'hA3; d[3] = 8'hA4;
    write_seq(8'h2E, d, 4, "R4 data ack");
    wait_prog();
    read_seq(8'h2E, 2, r);
    chk(r[0] == 8'hA1, "R4 byte at 2E", r[0], 8'hA1);
    chk(r[1] == 8'hA2, "R4 byte at 2F", r[1], 8'hA2);
    read_seq(8'h20, 3, r);
    chk(r[0] == 8'hA3, "R4 wrapped to 20", r[0], 8'hA3);
    chk(r[1] == 8'hA4, "R4 wrapped to 21", r[1], 8'hA4);
    chk(r[2] == 8'hFF, "R8 next byte 22 untouched", r[2], 8'hFF);
    read_seq(8'h30, 1, r);
    chk(r[0] == 8'hFF, "R4 next page untouched", r[0], 8'hFF);
  endtask

  task automatic t_repeated_start_discard();
    bytes_t r;
    bit ack;
    i2c_start();
    send_byte(ctl(pins, 1'b0), ack); send_byte(8'h50, ack);
    send_byte(8'h99, ack); chk(ack, "R3 data ack before restart", ack, 1);
    i2c_start();
    send_byte(ctl(pins, 1'b1), ack); chk(ack, "R1 restart control ack", ack, 1);
    recv_byte(1'b1, r[0]);
    i2c_stop();
    read_seq(8'h50, 1, r);
    chk(r[0] == 8'hFF, "R3 restart discards staged data", r[0], 8'hFF);
  endtask

  task automatic t_wp();
    bytes_t d, r;
    bit ack;
    wp = 1'b1;
    d[0] = 8'h33;
    write_seq(8'h10, d, 1, "R6 protected data ack");
    i2c_start(); send_byte(ctl(pins, 1'b0), ack);
    chk(ack, "R6 no window after protected write", ack, 1);
    i2c_stop();
    wp = 1'b0;
    read_seq(8'h10, 1, r);
    chk(r[0] == 8'h5A, "R6 protected byte unchanged", r[0], 8'h5A);
  endtask

  task automatic t_mismatch();
    bit ack;
    i2c_start(); send_byte(ctl(3'b100, 1'b0), ack);
    chk(!ack, "R2 strap mismatch nack", ack, 0);
    i2c_stop();
    i2c_start(); send_byte({4'b1011, pins, 1'b0}, ack);
    chk(!ack, "R2 type mismatch nack", ack, 0);
    i2c_stop();
  endtask

  task automatic t_seq_wrap();
    bytes_t d, r;
    d[0] = 8'h66;
    write_seq(8'h00, d, 1, "R8 data ack");
    wait_prog();
    d[0] = 8'h77;
    write_seq(8'h7F, d, 1, "R8 data ack");
    wait_prog();
    read_seq(8'h7F, 2, r);
    chk(r[0] == 8'h77, "R8 last word", r[0], 8'h77);
    chk(r[1] == 8'h66, "R8 wrap to zero", r[1], 8'h66);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_erased();
    t_byte_write();
    t_busy();
    t_page_wrap();
    t_repeated_start_discard();
    t_wp();
    t_mismatch();
    t_seq_wrap();
    chk(hi_moves == 0, "R10 SDA drive moved with SCL high", hi_moves, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule